// File: doc/BRIEF.md
# Summed Oscillator-Pair Soft-Decision PUF Evaluator

This block turns 2k free-running ring-oscillator signals into one signed soft-decision value for each evaluation. The oscillators are grouped into k pairs. For every evaluation a linear feedback shift register, seeded with a fixed challenge, is stepped k times to produce one challenge bit per pair. Each challenge bit chooses which oscillator of its pair adds to the "upper" sum and which adds to the "lower" sum. Two accumulators count the synchronized rising edges of their oscillator groups over a measurement window, given in reference-clock cycles. The output is upper minus lower, in two's complement. The hard bit is 1 only when that difference is strictly positive.

A caller loads a seed while the block is idle, pulses `start_i` with a window length, and waits for the one-cycle `done_o`. The oscillator gate `osc_en_o` is raised only while edges are being counted. The result is a plain registered value with no back-pressure. It stays unchanged from one `done_o` pulse until the next, so a consumer may read it at any time in between. Generator state carries over between evaluations, so successive evaluations see fresh challenge sets.

Top module: `puf_ksum_core`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `osc_en_o`, `hard_o` and `soft_o` are all zero.
- R2: A `seed_load_i` pulse while idle loads `seed_i` into the generator. A zero seed is replaced by 1. A `seed_load_i` pulse while busy is ignored.
- R3: The generator is a right-shifting Galois register (16 bits by default). On each step it outputs its bit 0 and, when that bit is 1, XORs the shifted state with taps 0xB400. Each evaluation takes exactly k steps. The n-th output bit (counting from 1) becomes the challenge of pair n-1. The state carries over to the next evaluation.
- R4: Pair i is oscillators 2i and 2i+1. With challenge 0, oscillator 2i feeds the upper sum and 2i+1 feeds the lower sum. With challenge 1 the two are swapped.
- R5: Each accumulator counts the synchronized rising edges of its routed oscillators. Counting happens on exactly W cycles, where W is the `window_i` value captured at start. `osc_en_o` is high on exactly those W cycles and on no others.
- R6: Each accumulator saturates at 2^CNT_W-1 and never wraps.
- R7: `soft_o` equals upper minus lower as a (CNT_W+1)-bit two's-complement value. `hard_o` is 1 if and only if that value is greater than zero, so equal sums give 0.
- R8: `done_o` is a single-cycle pulse, and `busy_o` is low while it is high. `soft_o` and `hard_o` change only together with a `done_o` pulse.
- R9: A `start_i` pulse while busy is ignored. It neither restarts the evaluation nor changes its window.
- R10: A window of 0 yields a result of 0 with `hard_o` = 0, and `osc_en_o` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an evaluation (taken only when idle) |
| window_i | input | WIN_W | Measurement window in clock cycles, captured at start |
| seed_load_i | input | 1 | Load the challenge seed (taken only when idle) |
| seed_i | input | LFSR_W | Challenge seed value |
| osc_i | input | 2*NUM_PAIRS | Asynchronous ring-oscillator outputs |
| osc_en_o | output | 1 | Oscillator run gate, high during counting |
| busy_o | output | 1 | Evaluation in progress |
| done_o | output | 1 | One-cycle pulse when a new result is valid |
| soft_o | output | CNT_W+1 | Signed soft-decision difference |
| hard_o | output | 1 | Sign bit decision (1 when difference > 0) |

## Verification
The bench builds the block with four pairs, 6-bit accumulators and an 8-bit window. This makes a full sweep of oscillator rate assignments and seeds small enough to run, and it lets a 64-cycle window drive the accumulators past their 63-count ceiling. Oscillators toggle with power-of-two half-periods, and the windows are multiples of the longest period. Every expected edge count is therefore an exact quotient, whatever the synchronizer phase, and the bench derives each challenge set from its own model of the generator. The bench also covers zero windows, zero seeds, equal sums, and start and seed pulses that arrive mid-evaluation.

// File: rtl/puf_ksum_pkg.sv
package puf_ksum_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EXPAND = 2'd1,
    ST_RUN    = 2'd2,
    ST_FIN    = 2'd3
  } eval_state_t;
endpackage

// File: rtl/puf_edge_sync.sv
// Two-flop synchronizer plus one history flop per oscillator; emits a
// single-cycle pulse on each synchronized rising edge.
module puf_edge_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [2:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[1:0], async_i[g]};
    end
    assign rise_o[g] = sh_q[1] & ~sh_q[2];

    // A rising edge needs a low sample before it: no back-to-back pulses (R5)
    p_rise_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/puf_chal_gen.sv
// Galois LFSR that is stepped once per cycle of expansion; each output bit
// shifts into the challenge register from the top.
module puf_chal_gen #(
  parameter int               LFSR_W   = 16,
  parameter logic [LFSR_W-1:0] TAPS    = 16'hB400,
  parameter logic [LFSR_W-1:0] RST_SEED = 16'hACE1,
  parameter int               K        = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic              step_i,
  output logic [K-1:0]      chal_o
);
  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] next_w;
  logic [K-1:0]      chal_q;

  assign next_w = (state_q >> 1) ^ (state_q[0] ? TAPS : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RST_SEED;
      chal_q  <= '0;
    end else if (load_i) begin
      state_q <= (seed_i == '0) ? LFSR_W'(1) : seed_i;
    end else if (step_i) begin
      state_q <= next_w;
      chal_q  <= {state_q[0], chal_q[K-1:1]};
    end
  end

  assign chal_o = chal_q;

  // Register never locks up in the all-zero state (R2)
  p_state_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  // Challenge only moves on a step (R3)
  p_chal_step_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(chal_q));
endmodule

// File: rtl/puf_route_sum.sv
// Routes each pair by its challenge bit and counts the edges landing on
// each side in the current cycle.
module puf_route_sum #(
  parameter int K     = 64,
  parameter int INC_W = 7
) (
  input  logic [2*K-1:0] rise_i,
  input  logic [K-1:0]   chal_i,
  output logic [INC_W-1:0] top_inc_o,
  output logic [INC_W-1:0] bot_inc_o
);
  always_comb begin
    top_inc_o = '0;
    bot_inc_o = '0;
    for (int i = 0; i < K; i++) begin
      if (chal_i[i]) begin
        top_inc_o = top_inc_o + INC_W'(rise_i[2*i+1]);
        bot_inc_o = bot_inc_o + INC_W'(rise_i[2*i]);
      end else begin
        top_inc_o = top_inc_o + INC_W'(rise_i[2*i]);
        bot_inc_o = bot_inc_o + INC_W'(rise_i[2*i+1]);
      end
    end
  end
endmodule

// File: rtl/puf_sat_acc.sv
// Saturating edge accumulator with synchronous clear.
module puf_sat_acc #(
  parameter int CNT_W = 16,
  parameter int INC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W:0] MAXV = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum_w;

  assign sum_w = {1'b0, cnt_q} + (CNT_W+1)'(inc_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= (sum_w > MAXV) ? MAXV[CNT_W-1:0] : sum_w[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;

  // Never wraps: without a clear the count does not decrease (R6)
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> cnt_o >= $past(cnt_o));
endmodule

// File: rtl/puf_ksum_core.sv
module puf_ksum_core
  import puf_ksum_pkg::*;
#(
  parameter int               NUM_PAIRS = 64,
  parameter int               CNT_W     = 16,
  parameter int               WIN_W     = 16,
  parameter int               LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] RST_SEED  = 16'hACE1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [WIN_W-1:0]       window_i,
  input  logic                   seed_load_i,
  input  logic [LFSR_W-1:0]      seed_i,
  input  logic [2*NUM_PAIRS-1:0] osc_i,
  output logic                   osc_en_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [CNT_W:0]         soft_o,
  output logic                   hard_o
);
  localparam int NUM_OSC = 2 * NUM_PAIRS;
  localparam int INC_W   = $clog2(NUM_PAIRS + 1);
  localparam int EXP_W   = $clog2(NUM_PAIRS + 1);
  localparam int SOFT_W  = CNT_W + 1;

  eval_state_t       state_q;
  logic [EXP_W-1:0]  exp_q;
  logic [WIN_W-1:0]  rem_q;
  logic [SOFT_W-1:0] soft_q;
  logic              hard_q;
  logic              done_q;

  logic [NUM_OSC-1:0]   rise_w;
  logic [NUM_PAIRS-1:0] chal_w;
  logic [INC_W-1:0]     top_inc_w, bot_inc_w;
  logic [CNT_W-1:0]     top_cnt_w, bot_cnt_w;
  logic signed [SOFT_W-1:0] diff_w;
  logic                 clr_w, count_w, step_w, load_w;

  assign clr_w   = (state_q == ST_IDLE) && start_i;
  assign count_w = (state_q == ST_RUN) && (rem_q != '0);
  assign step_w  = (state_q == ST_EXPAND);
  assign load_w  = (state_q == ST_IDLE) && seed_load_i;

  puf_edge_sync #(.N(NUM_OSC)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(osc_i), .rise_o(rise_w)
  );

  puf_chal_gen #(
    .LFSR_W(LFSR_W), .TAPS(LFSR_TAPS), .RST_SEED(RST_SEED), .K(NUM_PAIRS)
  ) u_chal (
    .clk(clk), .rst_n(rst_n), .load_i(load_w), .seed_i(seed_i),
    .step_i(step_w), .chal_o(chal_w)
  );

  puf_route_sum #(.K(NUM_PAIRS), .INC_W(INC_W)) u_route (
    .rise_i(rise_w), .chal_i(chal_w),
    .top_inc_o(top_inc_w), .bot_inc_o(bot_inc_w)
  );

  puf_sat_acc #(.CNT_W(CNT_W), .INC_W(INC_W)) u_top_acc (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_w), .en_i(count_w),
    .inc_i(top_inc_w), .cnt_o(top_cnt_w)
  );

  puf_sat_acc #(.CNT_W(CNT_W), .INC_W(INC_W)) u_bot_acc (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_w), .en_i(count_w),
    .inc_i(bot_inc_w), .cnt_o(bot_cnt_w)
  );

  assign diff_w = $signed({1'b0, top_cnt_w}) - $signed({1'b0, bot_cnt_w});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      exp_q   <= '0;
      rem_q   <= '0;
      soft_q  <= '0;
      hard_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_EXPAND;
          exp_q   <= '0;
          rem_q   <= window_i;
        end
        ST_EXPAND: begin
          exp_q <= exp_q + EXP_W'(1);
          if (exp_q == EXP_W'(NUM_PAIRS - 1)) state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (rem_q != '0) rem_q <= rem_q - WIN_W'(1);
          else             state_q <= ST_FIN;
        end
        ST_FIN: begin
          soft_q  <= diff_w;
          hard_q  <= (diff_w > 0);
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign osc_en_o = count_w;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign soft_o   = soft_q;
  assign hard_o   = hard_q;

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_FIN) |=> ($stable(soft_o) && $stable(hard_o)));
  p_gate_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en_o |-> busy_o);
  p_route_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en_o |=> $stable(chal_w));
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) && start_i |=> (state_q != ST_EXPAND));
endmodule

// File: tb/tb_puf_ksum_core.sv
`timescale 1ns/1ps
module tb_puf_ksum_core;
  localparam int K     = 4;
  localparam int NOSC  = 2 * K;
  localparam int CW    = 6;
  localparam int WW    = 8;
  localparam int MAXC  = (1 << CW) - 1;
  localparam logic [15:0] TAPS = 16'hB400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [WW-1:0] window_i = '0;
  logic seed_load_i = 1'b0;
  logic [15:0] seed_i = '0;
  logic [NOSC-1:0] osc_i;
  logic osc_en_o, busy_o, done_o, hard_o;
  logic [CW:0] soft_o;

  int checks = 0;
  int fails = 0;
  int h [NOSC];
  int tc [NOSC];
  logic [15:0] m_lfsr = 16'hACE1;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  puf_ksum_core #(.NUM_PAIRS(K), .CNT_W(CW), .WIN_W(WW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .window_i(window_i),
    .seed_load_i(seed_load_i), .seed_i(seed_i), .osc_i(osc_i),
    .osc_en_o(osc_en_o), .busy_o(busy_o), .done_o(done_o),
    .soft_o(soft_o), .hard_o(hard_o)
  );

  // Free-running oscillator models with programmable half-periods
  initial begin
    osc_i = '0;
    for (int j = 0; j < NOSC; j++) begin h[j] = 1; tc[j] = 0; end
    forever begin
      @(negedge clk);
      for (int j = 0; j < NOSC; j++) begin
        tc[j] = tc[j] + 1;
        if (tc[j] >= h[j]) begin tc[j] = 0; osc_i[j] = ~osc_i[j]; end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic set_rates(int p);
    for (int j = 0; j < NOSC; j++) h[j] = 1 << ((j * 3 + p) % 4);
  endtask

  task automatic load_seed(logic [15:0] s);
    @(negedge clk);
    seed_i = s; seed_load_i = 1'b1;
    @(negedge clk);
    seed_load_i = 1'b0;
    m_lfsr = (s == 16'h0) ? 16'h1 : s;
  endtask

  task automatic run_eval(int w, bit poke, string tag);
    int cnt [NOSC];
    int top, bot, exps, cyc, en_cnt;
    bit c, got;
    logic [CW:0] held;
    top = 0; bot = 0;
    for (int j = 0; j < NOSC; j++) cnt[j] = (w == 0) ? 0 : w / (2 * h[j]);
    for (int i = 0; i < K; i++) begin
      c = m_lfsr[0];
      m_lfsr = (m_lfsr >> 1) ^ (c ? TAPS : 16'h0);
      if (c) begin top += cnt[2*i+1]; bot += cnt[2*i]; end
      else   begin top += cnt[2*i];   bot += cnt[2*i+1]; end
    end
    if (top > MAXC) top = MAXC;
    if (bot > MAXC) bot = MAXC;
    exps = top - bot;

    @(negedge clk);
    window_i = WW'(w); start_i = 1'b1;
    cyc = 0; en_cnt = 0; got = 1'b0;
    while (!got && cyc < 3000) begin
      @(negedge clk);
      if (cyc == 0) start_i = 1'b0;
      if (poke && cyc == 3) begin
        start_i = 1'b1; window_i = 8'd200; seed_load_i = 1'b1; seed_i = 16'h1234;
      end
      if (poke && cyc == 4) begin start_i = 1'b0; seed_load_i = 1'b0; end
      if (osc_en_o) en_cnt++;
      if (done_o) got = 1'b1;
      cyc++;
    end
    chk({tag, " R8 done seen"}, int'(got), 1);
    chk({tag, " R7 R4 R3 soft"}, int'($signed(soft_o)), exps);
    chk({tag, " R7 hard"}, int'(hard_o), (exps > 0) ? 1 : 0);
    chk({tag, " R5 gate cycles"}, en_cnt, w);
    held = soft_o;
    @(negedge clk);
    chk({tag, " R8 single pulse"}, int'(done_o), 0);
    chk({tag, " R8 held"}, int'(soft_o), int'(held));
    chk({tag, " R9 idle after done"}, int'(busy_o), 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 gate", int'(osc_en_o), 0);
    chk("R1 soft", int'(soft_o), 0);
    chk("R1 hard", int'(hard_o), 0);
    rst_n = 1'b1;
    settle();

    // R3: reset seed, then state carried across evaluations
    set_rates(0); settle();
    run_eval(16, 1'b0, "reset-seed");
    run_eval(16, 1'b0, "carry");

    // Sweep rate assignments and seeds (R3, R4, R5, R7)
    for (int p = 0; p < 8; p++) begin
      set_rates(p); settle();
      if (p % 2 == 0) load_seed(16'h1357 + 16'(p * 16'h2F1));
      run_eval(16, 1'b0, "sweep");
      run_eval(32, 1'b0, "sweep32");
    end

    // R2: zero seed becomes 1
    load_seed(16'h0);
    set_rates(3); settle();
    run_eval(16, 1'b0, "R2 zero-seed");

    // R6: saturation with fast oscillators on one side of each pair
    for (int j = 0; j < NOSC; j++) h[j] = (j % 2 == 0) ? 1 : 8;
    settle();
    load_seed(16'h00FF);
    run_eval(64, 1'b0, "R6 sat-mixed");
    run_eval(64, 1'b0, "R6 sat-mixed2");
    // R6, R7: both sides saturate, equal sums give hard 0
    for (int j = 0; j < NOSC; j++) h[j] = 1;
    settle();
    run_eval(64, 1'b0, "R6 sat-both");

    // R10: zero window
    set_rates(1); settle();
    run_eval(0, 1'b0, "R10 zero-window");

    // R9, R2: start and seed pulses while busy are ignored
    set_rates(2); settle();
    run_eval(16, 1'b1, "R9 busy-poke");
    run_eval(16, 1'b0, "R2 after-poke");

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule